// File: doc/BRIEF.md
# Tile-Mapped Pixel Generator

This block turns a raster position into a 3-bit RGB colour for a 640x480 visible area. It does not keep one colour word per screen location. The screen is divided into 8x8 pixel tiles, which gives 80 tile columns by 60 tile rows. Each tile position stores a 5-bit pattern number. That number picks one of 32 monochrome 8x8 bitmaps. The bit for the pixel's place inside the tile then selects between a foreground colour and a background colour. Both colours can be set at run time.

A timing generator supplies the current column and row, a video-enable flag and a pixel-rate strobe. The lookup pipeline advances only on that strobe. The tile read and the pattern read are both synchronous. The low column bits and the video flag are delayed so that they stay aligned with the bitmap row they select from. A host fills both stores through two independent write ports. These writes may happen at any time, including during active video.

Top module: `tile_pixel_gen`

## Requirements
- R1: While reset is asserted, and until two pixel strobes have been accepted after reset, `rgb` is 000.
- R2: The tile entry used for pixel (col,row) is entry (row/8)*80 + col/8 of the tile store, which has 80x60 entries of 5 bits; `tile_waddr` uses this same numbering.
- R3: The pattern store is written at address {pattern number, row within tile} (`pat_waddr` bits [7:3] are the pattern and bits [2:0] the tile row). Bit col%8 of that 8-bit row is the pixel, so bit 0 is the leftmost pixel of the tile.
- R4: With video enabled, a set pattern bit gives `rgb` = `fg_color` and a clear bit gives `rgb` = `bg_color`. Both colour inputs are read at the output and can change between frames.
- R5: A pixel presented with `video_en` low gives `rgb` = 000, whatever the memories hold and whatever the coordinates are, even off-screen ones.
- R6: A pixel presented with pixel strobe k appears on `rgb` after the clock edge of strobe k+1. It stays there until the edge of strobe k+2.
- R7: In a cycle with `pix_en` low the pipeline holds its state. With both colours steady, `rgb` does not change.
- R8: A write to either store is seen by every read of that location in a later clock cycle, including a pixel strobed in the very next cycle.
- R9: All 32 pattern numbers select their own distinct bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate strobe; advances the lookup pipeline |
| video_en | input | 1 | High when the presented pixel is in the visible area |
| pix_col | input | 10 | Current pixel column (0 at left) |
| pix_row | input | 10 | Current pixel row (0 at top) |
| fg_color | input | 3 | Colour for set pattern bits |
| bg_color | input | 3 | Colour for clear pattern bits |
| tile_we | input | 1 | Tile store write enable |
| tile_waddr | input | 13 | Tile store write address, (row/8)*80 + col/8 |
| tile_wdata | input | 5 | Pattern number to store |
| pat_we | input | 1 | Pattern store write enable |
| pat_waddr | input | 8 | Pattern store write address {pattern, tile row} |
| pat_wdata | input | 8 | Bitmap row, bit 0 leftmost |
| rgb | output | 3 | Pixel colour |

## Verification
The hardest case to reach from the ports is a pipeline stalled in the middle of a lookup. Here the strobe drops after the tile read but before the pattern read, and the delayed column bits must stay tied to the right bitmap row. The stimulus reaches it by streaming a scan line with idle cycles of varying length between strobes. A scoreboard pops one expected colour per accepted strobe, so any slip between the delayed column bits and the data would show as a mismatch. Write-then-read in the very next cycle, and the tile-row seams at rows 7/8 and 479, are driven directly.

// File: rtl/tile_pixel_gen.sv
module tile_pixel_gen #(
  parameter int PIX_W     = 10,
  parameter int TILE_LOG2 = 3,
  parameter int TILE_COLS = 80,
  parameter int TILE_ROWS = 60,
  parameter int PAT_W     = 5,
  parameter int RGB_W     = 3,
  localparam int TILE_PX    = 1 << TILE_LOG2,
  localparam int TILE_DEPTH = TILE_COLS * TILE_ROWS,
  localparam int TADDR_W    = $clog2(TILE_DEPTH),
  localparam int PADDR_W    = PAT_W + TILE_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               video_en,
  input  logic [PIX_W-1:0]   pix_col,
  input  logic [PIX_W-1:0]   pix_row,
  input  logic [RGB_W-1:0]   fg_color,
  input  logic [RGB_W-1:0]   bg_color,
  input  logic               tile_we,
  input  logic [TADDR_W-1:0] tile_waddr,
  input  logic [PAT_W-1:0]   tile_wdata,
  input  logic               pat_we,
  input  logic [PADDR_W-1:0] pat_waddr,
  input  logic [TILE_PX-1:0] pat_wdata,
  output logic [RGB_W-1:0]   rgb
);
  localparam int PAT_DEPTH = 1 << PADDR_W;
  localparam int SUM_W     = 2 * PIX_W + 1;

  logic [PAT_W-1:0]   tile_mem [TILE_DEPTH];
  logic [TILE_PX-1:0] pat_mem  [PAT_DEPTH];

  logic [SUM_W-1:0]     tsum;
  logic                 thit;
  logic [PAT_W-1:0]     idx_q;
  logic [TILE_PX-1:0]   prow_q;
  logic [TILE_LOG2-1:0] trow_q, tcol_q1, tcol_q2;
  logic                 vid_q1, vid_q2;

  assign tsum = SUM_W'(pix_row[PIX_W-1:TILE_LOG2]) * SUM_W'(TILE_COLS)
              + SUM_W'(pix_col[PIX_W-1:TILE_LOG2]);
  assign thit = (tsum < SUM_W'(TILE_DEPTH));

  always_ff @(posedge clk) begin
    if (tile_we && (tile_waddr < TADDR_W'(TILE_DEPTH)))
      tile_mem[tile_waddr] <= tile_wdata;
  end

  always_ff @(posedge clk) begin
    if (pat_we) pat_mem[pat_waddr] <= pat_wdata;
  end

  always_ff @(posedge clk) begin
    if (pix_en) begin
      idx_q  <= thit ? tile_mem[tsum[TADDR_W-1:0]] : '0;
      prow_q <= pat_mem[{idx_q, trow_q}];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trow_q  <= '0;
      tcol_q1 <= '0;
      tcol_q2 <= '0;
      vid_q1  <= 1'b0;
      vid_q2  <= 1'b0;
    end else if (pix_en) begin
      trow_q  <= pix_row[TILE_LOG2-1:0];
      tcol_q1 <= pix_col[TILE_LOG2-1:0];
      tcol_q2 <= tcol_q1;
      vid_q1  <= video_en;
      vid_q2  <= vid_q1;
    end
  end

  assign rgb = !vid_q2 ? '0 : (prow_q[tcol_q2] ? fg_color : bg_color);
endmodule

module tile_pixel_gen_chk #(
  parameter int RGB_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             video_en,
  input logic [RGB_W-1:0] fg_color,
  input logic [RGB_W-1:0] bg_color,
  input logic [RGB_W-1:0] rgb
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (rgb == '0));

  // R5
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && $past(pix_en) && $past(pix_en, 2) && !$past(video_en, 2))
    |-> (rgb == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd1) && !$past(pix_en) && $stable(fg_color) && $stable(bg_color))
    |-> $stable(rgb));

  // R4
  colour_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb != '0) |-> ((rgb == fg_color) || (rgb == bg_color)));
endmodule

bind tile_pixel_gen tile_pixel_gen_chk #(.RGB_W(RGB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .video_en(video_en),
  .fg_color(fg_color), .bg_color(bg_color), .rgb(rgb)
);

// File: tb/test_tile_pixel_gen.sv
module test_tile_pixel_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0, video_en = 1'b0;
  logic [9:0]  pix_col = '0, pix_row = '0;
  logic [2:0]  fg_color = '0, bg_color = '0;
  logic        tile_we = 1'b0, pat_we = 1'b0;
  logic [12:0] tile_waddr = '0;
  logic [4:0]  tile_wdata = '0;
  logic [7:0]  pat_waddr = '0, pat_wdata = '0;
  logic [2:0]  rgb;

  tile_pixel_gen i_tile_pixel_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .video_en(video_en),
    .pix_col(pix_col), .pix_row(pix_row), .fg_color(fg_color), .bg_color(bg_color),
    .tile_we(tile_we), .tile_waddr(tile_waddr), .tile_wdata(tile_wdata),
    .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata), .rgb(rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] tmodel [4800];
  logic [7:0] pmodel [256];
  logic [2:0] exp_q [$];
  string      tag_q [$];
  int checks = 0, fails = 0, strobes = 0;
  logic fired = 1'b0;
  bit done = 0;

  task automatic chk(bit ok, string tg, logic [2:0] act, logic [2:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: rgb=%b expected=%b at t=%0t", tg, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] pgen(int p, int r);
    return 8'((p * 8 + r) * 29 + 7) ^ 8'(p << (r % 4));
  endfunction

  function automatic logic [2:0] model(int c, int r, bit v);
    logic [4:0] t;
    logic [7:0] b;
    if (!v) return 3'b000;
    t = tmodel[(r / 8) * 80 + c / 8];
    b = pmodel[int'(t) * 8 + r % 8];
    return b[c % 8] ? fg_color : bg_color;
  endfunction

  task automatic wr_tile(int a, logic [4:0] d);
    tile_we = 1'b1; tile_waddr = 13'(a); tile_wdata = d; tmodel[a] = d;
    @(posedge clk); #1;
    tile_we = 1'b0;
  endtask

  task automatic wr_pat(int p, int r, logic [7:0] d);
    pat_we = 1'b1; pat_waddr = {5'(p), 3'(r)}; pat_wdata = d; pmodel[p * 8 + r] = d;
    @(posedge clk); #1;
    pat_we = 1'b0;
  endtask

  task automatic strobe(int c, int r, bit v, string tg);
    pix_col = 10'(c); pix_row = 10'(r); video_en = v; pix_en = 1'b1;
    exp_q.push_back(model(c, r, v));
    tag_q.push_back(tg);
    @(posedge clk); #1;
    pix_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic flush();
    strobe(700, 500, 1'b0, "R5");
    strobe(700, 500, 1'b0, "R5");
  endtask

  task automatic scan(int r, string tg);
    for (int c = 0; c < 640; c++) strobe(c, r, 1'b1, tg);
  endtask

  always @(posedge clk) fired <= pix_en & rst_n;

  always @(negedge clk) begin
    if (!rst_n) strobes = 0;
    else if (fired) begin
      strobes++;
      if (strobes == 1) chk(rgb == 3'b000, "R1", rgb, 3'b000);
      else if (exp_q.size() > 0) begin
        logic [2:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(rgb === e, tg, rgb, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rgb == 3'b000, "R1", rgb, 3'b000);
    rst_n = 1'b1;
    idle(2);
    chk(rgb == 3'b000, "R1", rgb, 3'b000);

    fg_color = 3'b101;
    bg_color = 3'b011;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 8; r++) wr_pat(p, r, pgen(p, r));
    for (int tc = 0; tc < 80; tc++) begin
      wr_tile(tc, 5'((tc * 7) % 32));
      wr_tile(80 + tc, 5'((tc * 7 + 3) % 32));
      wr_tile(59 * 80 + tc, 5'((tc * 7 + 11) % 32));
    end

    // R2 R3 R4 R9: full scan lines across tile rows 0, 1 and 59
    scan(0, "R2");
    scan(7, "R3");
    scan(8, "R6");
    scan(13, "R9");
    scan(479, "R2");

    // R7: irregular stalls between strobes
    for (int c = 0; c < 96; c++) begin
      strobe(c, 9, 1'b1, "R7");
      idle(c % 4);
    end

    // R5: video gaps inside a line
    for (int c = 0; c < 40; c++) strobe(c, 0, (c % 5) != 0, "R5");
    flush();

    // R8: write then read in the next cycle
    wr_tile(3, 5'd17);
    for (int c = 24; c < 32; c++) strobe(c, 2, 1'b1, "R8");
    flush();
    wr_pat(17, 5, 8'hA5);
    for (int c = 24; c < 32; c++) strobe(c, 5, 1'b1, "R8");
    flush();

    // R4: new colours after the pipeline is blank
    fg_color = 3'b110;
    bg_color = 3'b001;
    for (int c = 0; c < 128; c++) strobe(c, 4, 1'b1, "R4");
    flush();
    idle(3);
    chk(rgb == 3'b000, "R5", rgb, 3'b000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule